// File: doc/BRIEF.md
# Pipelined Binary-to-Residue Converter

This block turns an unsigned binary word into its residue with respect to one fixed modulus of at most five bits. It accepts a fresh word on every clock edge and returns the matching residue a fixed number of cycles later. The output valid flag is the input valid flag, delayed by that latency.

The input word is cut into five-bit slices, and the topmost slice may be narrower. Each slice has a positional weight of 2^(5i). For every slice, a small constant table built at elaboration gives the slice value times that weight, reduced mod m. The slice residues are summed in carry-save form, so no carry ripples through that stage. The two carry-save vectors are then each folded below m, which puts their sum below 2m. A last two-operand modular adder forms both x and x−m side by side and keeps x−m whenever it is non-negative.

The pipeline has five register stages: input capture, slice residues, carry-save vectors, partial reduction and the final residue. It is meant to sit in front of residue-arithmetic datapaths that need one conversion per cycle.

Top module: `b2r_converter`

## Requirements
- R1: An active-low synchronous reset (`rst_n` = 0 at a rising edge) clears every stage valid flag. `out_valid` reads 0 while reset is held, and no word that was in flight before the reset ever appears afterwards.
- R2: `out_valid` equals `in_valid` delayed by exactly 5 rising edges. A word can be presented on every cycle with no gap, and idle cycles (`in_valid` = 0) give idle output cycles at the same 5-cycle offset.
- R3: Slice i covers input bits [5i+4:5i]. Its contribution is (slice · 2^(5i)) mod MOD, which is always below MOD.
- R4: The two carry-save vectors add up exactly to the sum of all slice residues, with no lost carry.
- R5: After partial reduction, each of the two operands handed to the final adder is below MOD, so their sum is below 2·MOD.
- R6: When `out_valid` is 1, `out_res` equals the input word mod MOD and is below MOD. This holds for 0, all ones, MOD−1, MOD, multiples of MOD and the largest multiple of MOD that fits in the word.
- R7: The top slice is narrower when DATA_W is not a multiple of 5 (bits [31:30] for the default width). Words with only those bits set convert correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The word on `in_data` is to be converted |
| in_data | input | DATA_W | Unsigned binary word |
| out_valid | output | 1 | `out_res` holds a result |
| out_res | output | $clog2(MOD) | Residue of the word, 0 to MOD−1 |

## Verification
Two functions can fall in the same clock: a new word is captured at the input while an older word's residue leaves the final adder. On top of that, three intermediate words sit in the middle stages. The bench provokes this with long gap-free bursts and with random valid gaps. It also applies a reset while words are in flight, so that stage flags are cleared at the same moment new input is offered. Every output cycle is judged against a bench-side delay line of the inputs, 5 entries deep. The expected residue comes from a bit-serial remainder that shares nothing with the slice method.

// File: rtl/b2r_pkg.sv
package b2r_pkg;

  // 2^e mod m, by repeated doubling
  function automatic int unsigned pow2_mod(input int unsigned e, input int unsigned m);
    int unsigned r;
    r = 1 % m;
    for (int unsigned k = 0; k < e; k++) r = (r * 2) % m;
    return r;
  endfunction

  // residue of a slice value placed at bit position pos
  function automatic int unsigned slice_res(input int unsigned s, input int unsigned pos,
                                            input int unsigned m);
    return (s * pow2_mod(pos, m)) % m;
  endfunction

  // fold a small carry-save vector below m
  function automatic int unsigned fold_mod(input int unsigned x, input int unsigned m);
    return x % m;
  endfunction

endpackage

// File: rtl/b2r_slice_lut.sv
module b2r_slice_lut #(
  parameter int SLICE_BITS = 5,
  parameter int POS        = 0,
  parameter int MOD        = 27,
  parameter int RW         = 5
) (
  input  logic [SLICE_BITS-1:0] slice,
  output logic [RW-1:0]         res
);
  import b2r_pkg::*;

  localparam int ENTRIES = 1 << SLICE_BITS;

  logic [RW-1:0] table_q [ENTRIES];

  for (genvar v = 0; v < ENTRIES; v++) begin : g_ent
    assign table_q[v] = RW'(slice_res(v, POS, MOD));
  end

  assign res = table_q[slice];

endmodule

// File: rtl/b2r_csa_sum.sv
module b2r_csa_sum #(
  parameter int N_OP = 7,
  parameter int RW   = 5,
  parameter int SW   = 8
) (
  input  logic [N_OP-1:0][RW-1:0] ops,
  output logic [SW-1:0]           sum_vec,
  output logic [SW-1:0]           car_vec
);
  logic [SW-1:0] s, c, t, ns, nc;

  always_comb begin
    s = SW'(ops[0]);
    c = '0;
    for (int k = 1; k < N_OP; k++) begin
      t  = SW'(ops[k]);
      ns = s ^ c ^ t;
      nc = ((s & c) | (s & t) | (c & t)) << 1;
      s  = ns;
      c  = nc;
    end
    sum_vec = s;
    car_vec = c;
  end

endmodule

// File: rtl/b2r_mod_add.sv
module b2r_mod_add #(
  parameter int MOD = 27,
  parameter int RW  = 5
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] res
);
  localparam int XW = RW + 1;

  logic [XW-1:0] x;
  logic [XW:0]   d;
  logic          keep_diff;

  always_comb begin
    x         = {1'b0, a} + {1'b0, b};
    d         = {1'b0, x} - (XW+1)'(MOD);
    keep_diff = ~d[XW];
    res       = keep_diff ? d[RW-1:0] : x[RW-1:0];
  end

endmodule

// File: rtl/b2r_converter.sv
module b2r_converter #(
  parameter int DATA_W = 32,
  parameter int MOD    = 27,
  parameter int SEG_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  output logic [$clog2(MOD)-1:0]   out_res
);
  import b2r_pkg::*;

  localparam int RW      = $clog2(MOD);
  localparam int NSEG    = (DATA_W + SEG_W - 1) / SEG_W;
  localparam int SUM_MAX = NSEG * (MOD - 1);
  localparam int SW      = $clog2(SUM_MAX + 1);

  // stage 0: input capture
  logic [DATA_W-1:0] in_q;
  logic              v0, v1, v2, v3, v4;

  // stage 1: slice residues
  logic [NSEG-1:0][RW-1:0] seg_w, seg_q;

  // stage 2: carry-save vectors
  logic [SW-1:0] csa_s_w, csa_c_w, csa_s_q, csa_c_q;

  // stage 3: partial reduction (each below MOD, pair below 2*MOD)
  logic [RW-1:0] part_a_w, part_b_w, part_a_q, part_b_q;

  // stage 4: final residue
  logic [RW-1:0] fin_w, fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
    end else begin
      v0 <= in_valid; v1 <= v0; v2 <= v1; v3 <= v2; v4 <= v3;
    end
  end

  always_ff @(posedge clk) begin
    in_q     <= in_data;
    seg_q    <= seg_w;
    csa_s_q  <= csa_s_w;
    csa_c_q  <= csa_c_w;
    part_a_q <= part_a_w;
    part_b_q <= part_b_w;
    fin_q    <= fin_w;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int LO  = i * SEG_W;
    localparam int WID = (DATA_W - LO < SEG_W) ? (DATA_W - LO) : SEG_W;
    b2r_slice_lut #(
      .SLICE_BITS(WID), .POS(LO), .MOD(MOD), .RW(RW)
    ) u_lut (
      .slice(in_q[LO +: WID]),
      .res  (seg_w[i])
    );
  end

  b2r_csa_sum #(.N_OP(NSEG), .RW(RW), .SW(SW)) u_csa (
    .ops    (seg_q),
    .sum_vec(csa_s_w),
    .car_vec(csa_c_w)
  );

  assign part_a_w = RW'(fold_mod(32'(csa_s_q), MOD));
  assign part_b_w = RW'(fold_mod(32'(csa_c_q), MOD));

  b2r_mod_add #(.MOD(MOD), .RW(RW)) u_add (
    .a  (part_a_q),
    .b  (part_b_q),
    .res(fin_w)
  );

  assign out_valid = v4;
  assign out_res   = fin_q;

  // ---- named observation points for the assertions ----
  logic          seg_all_below;
  logic [SW-1:0] seg_total;

  always_comb begin
    seg_all_below = 1'b1;
    seg_total     = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (32'(seg_q[i]) >= MOD) seg_all_below = 1'b0;
      seg_total = seg_total + SW'(seg_q[i]);
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v0 == $past(in_valid)) && (v1 == $past(v0)) &&
                     (v2 == $past(v1)) && (v3 == $past(v2)) && (out_valid == $past(v3)));

  p_reset_clears_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> !v0 && !v1 && !v2 && !v3 && !out_valid);

  p_slice_below_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> seg_all_below);

  p_csa_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> ({1'b0, csa_s_q} + {1'b0, csa_c_q}) == {1'b0, $past(seg_total)});

  p_part_below_2m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> (32'(part_a_q) < MOD) && (32'(part_b_q) < MOD));

  p_final_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_res) < MOD) &&
                  (32'(out_res) == (32'($past(part_a_q)) + 32'($past(part_b_q))) % MOD));

endmodule

// File: tb/b2r_converter_test.sv
module b2r_converter_test;

  localparam int DATA_W = 32;
  localparam int MOD    = 27;
  localparam int RW     = $clog2(MOD);
  localparam int LAT    = 5;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              out_valid;
  logic [RW-1:0]     out_res;

  int n_chk;
  int n_bad;

  logic              hv [1:LAT];
  logic [DATA_W-1:0] hd [1:LAT];
  string             ht [1:LAT];

  b2r_converter #(.DATA_W(DATA_W), .MOD(MOD), .SEG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_res(out_res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bit-serial remainder, MSB first
  function automatic int unsigned ref_mod(input logic [DATA_W-1:0] x);
    int unsigned r;
    r = 0;
    for (int i = DATA_W - 1; i >= 0; i--) r = (r * 2 + (x[i] ? 1 : 0)) % MOD;
    return r;
  endfunction

  task automatic clear_hist();
    for (int k = 1; k <= LAT; k++) begin
      hv[k] = 1'b0; hd[k] = '0; ht[k] = "R2";
    end
  endtask

  // check the output due now, then present the next word
  task automatic step(input logic v, input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    n_chk++;
    if (out_valid !== hv[LAT]) begin
      n_bad++;
      $display("FAIL R2 out_valid: actual=%b expected=%b", out_valid, hv[LAT]);
    end
    if (hv[LAT]) begin
      n_chk++;
      if (32'(out_res) !== ref_mod(hd[LAT])) begin
        n_bad++;
        $display("FAIL %s residue of %h: actual=%0d expected=%0d",
                 ht[LAT], hd[LAT], out_res, ref_mod(hd[LAT]));
      end
    end
    for (int k = LAT; k > 1; k--) begin
      hv[k] = hv[k-1]; hd[k] = hd[k-1]; ht[k] = ht[k-1];
    end
    hv[1] = v; hd[1] = d; ht[1] = tag;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic hold_reset(input int cycles);
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    clear_hist();
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 out_valid in reset: actual=%b expected=0", out_valid);
      end
    end
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] top_mult;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    clear_hist();
    void'($urandom(32'd20240611));

    // R1: reset state
    hold_reset(4);
    for (int k = 0; k < 3; k++) step(1'b0, '0, "R1");

    // R6: directed corners, back to back
    top_mult = DATA_W'((64'(1) << DATA_W) - 1) / MOD * MOD;
    step(1'b1, '0, "R6");
    step(1'b1, '1, "R6");
    step(1'b1, DATA_W'(MOD - 1), "R6");
    step(1'b1, DATA_W'(MOD), "R6");
    step(1'b1, DATA_W'(MOD + 1), "R6");
    step(1'b1, DATA_W'(2 * MOD), "R6");
    step(1'b1, DATA_W'(MOD * MOD * MOD), "R6");
    step(1'b1, top_mult, "R6");
    step(1'b1, top_mult + DATA_W'(MOD - 1), "R6");
    step(1'b1, top_mult - DATA_W'(1), "R6");

    // R3: one slice at a time, full and single-bit
    for (int i = 0; i < 7; i++) begin
      step(1'b1, DATA_W'(64'h1F << (5 * i)), "R3");
      step(1'b1, DATA_W'(64'h1 << (5 * i)), "R3");
    end

    // R7: only the narrow top slice set
    step(1'b1, 32'h8000_0000, "R7");
    step(1'b1, 32'h4000_0000, "R7");
    step(1'b1, 32'hC000_0000, "R7");
    step(1'b1, 32'hC000_001F, "R7");

    // R4 / R5: every slice large, carries in every column
    step(1'b1, 32'h7FFF_FFFF, "R4");
    step(1'b1, 32'h5555_5555, "R4");
    step(1'b1, 32'hAAAA_AAAA, "R5");
    step(1'b1, 32'hFFFF_FFFE, "R5");

    // R2: idle cycles between words
    step(1'b0, 32'h1234_5678, "R2");
    step(1'b1, 32'h0000_00FF, "R2");
    step(1'b0, '0, "R2");
    step(1'b0, '0, "R2");
    step(1'b1, 32'hDEAD_BEEF, "R2");

    // R2 / R6: random stream with random gaps and multiples of MOD
    for (int n = 0; n < 3000; n++) begin
      logic [DATA_W-1:0] d;
      logic v;
      int unsigned pick;
      pick = $urandom_range(0, 9);
      v    = ($urandom_range(0, 3) != 0);
      if (pick == 0)      d = DATA_W'($urandom_range(0, 32'h0976_2C5F) * MOD);
      else if (pick == 1) d = DATA_W'($urandom_range(0, 4 * MOD));
      else                d = DATA_W'($urandom);
      step(v, d, "R6");
    end

    // R1: reset while words are in flight, none may emerge afterwards
    for (int n = 0; n < 4; n++) step(1'b1, DATA_W'($urandom), "R6");
    hold_reset(2);
    for (int n = 0; n < LAT + 2; n++) step(1'b0, '0, "R1");

    // R2: full-rate burst after reset
    for (int n = 0; n < 500; n++) step(1'b1, DATA_W'($urandom), "R2");

    for (int n = 0; n < LAT + 1; n++) step(1'b0, '0, "R2");

    summary();
    $finish;
  end

endmodule